// File: doc/BRIEF.md
# Indirect-Indexed Video Controller Register Bank

This block is the host-side register bank of a video display controller. A host reaches it through a 2-bit port address and an 8-bit data bus. The port position with address bit 1 low holds a 5-bit register index on writes and returns an interrupt status byte on reads. The positions with address bit 1 high give byte-wise access to the 16-bit register that the latched index selects. Address bit 0 picks the low or the high byte lane.

The bank keeps six sticky interrupt-pending flags. Single-cycle event pulses from the rest of the controller set them. Together with their enable bits they drive a single interrupt line. A status read returns the flags and clears them.

The bank also decodes control, memory-width, DMA-control, scroll, raster-compare, address and length registers into fields that the display pipeline and the DMA engine use. A high-byte write to the length register, or to the sprite-table source register, emits a one-cycle start pulse. A write to the vertical scroll register also reloads the running vertical line counter.

Top module: `vrb_top`

## Requirements
- R1: A write to port 0 (address 2'b00) stores data bits 4:0 as the register index, which takes effect from the next cycle. A write to port 1 (2'b01) changes nothing.
- R2: A read of port 0 returns the pending flags on host_rdata in the same cycle, with bits 7:6 at 0. The flag order is: bit0 collision, bit1 overflow, bit2 raster-line match, bit3 sprite-table transfer done, bit4 VRAM DMA done, bit5 vertical blank. A read of port 1, 2 or 3 returns 0x00.
- R3: A read of port 0 or port 1 clears all pending flags at the next edge. An event pulse arriving in that same cycle wins, so its flag is pending afterwards.
- R4: An event pulse on evt_pulse[i] sets pending flag i, and the flag stays set until a status read. irq is the OR of each pending flag ANDed with its enable.
- R5: Index 5 low byte: bit0 collision enable, bit1 overflow enable, bit2 line-match enable, bit3 vblank enable, bits5:4 sync_mode, bit6 sprite_on, bit7 bg_on. Index 5 high byte: bits1:0 disp_mode, bit2 refresh_on, bits4:3 increment select.
- R6: Increment select codes 0, 1, 2 and 3 give a vram_step of 1, 32, 64 and 128.
- R7: Index 9 takes only low-byte writes. Bits1:0 give vram_timing and bits3:2 give sprite_timing. Bits5:4 give a map_width of 32, 64, 128 or 128. Bit6 gives a map_height of 32 or 64. Bit7 gives colour_mode. A high-byte write to index 9 is ignored.
- R8: Indices 6, 7, 8, 16, 17, 18 and 19 are 16-bit registers (line_compare, hscroll, vscroll, dma_src, dma_dst, dma_len, sat_src). Port 2 writes their low byte and port 3 writes their high byte.
- R9: A write to either byte of index 8 loads vline_count with the full 16-bit scroll value that results from that write.
- R10: Index 15 takes only low-byte writes. Bit0 is the VRAM-DMA interrupt enable, bit1 the sprite-table interrupt enable, bit2 dma_src_dec, bit3 dma_dst_dec and bit4 sat_repeat. A high-byte write to index 15 is ignored.
- R11: A port 3 write to index 18 raises dma_start for exactly the next cycle. A port 3 write to index 19 raises sat_request for exactly the next cycle. Low-byte writes raise neither.
- R12: Writes to indices with no register leave all outputs unchanged. After reset every field is 0 except vram_step, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe (never high together with host_rd) |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Port address: bit1 picks index/status or data, bit0 picks the byte lane |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of host_rd |
| evt_pulse | input | 6 | Single-cycle interrupt events, in status-bit order |
| irq | output | 1 | Interrupt request |
| sync_mode | output | 2 | External sync mode |
| sprite_on | output | 1 | Sprite layer enable |
| bg_on | output | 1 | Background layer enable |
| disp_mode | output | 2 | Display output mode |
| refresh_on | output | 1 | Memory refresh enable |
| vram_step | output | 8 | VRAM address step |
| vram_timing | output | 2 | VRAM access timing mode |
| sprite_timing | output | 2 | Sprite access timing mode |
| map_width | output | 8 | Background map width in tiles |
| map_height | output | 7 | Background map height in tiles |
| colour_mode | output | 1 | Colour mode select |
| line_compare | output | 16 | Raster compare line |
| hscroll | output | 16 | Horizontal scroll |
| vscroll | output | 16 | Vertical scroll |
| vline_count | output | 16 | Running vertical counter, reloaded by scroll writes |
| dma_src | output | 16 | DMA source address |
| dma_dst | output | 16 | DMA destination address |
| dma_len | output | 16 | DMA length |
| sat_src | output | 16 | Sprite-table source address |
| dma_src_dec | output | 1 | DMA source step mode |
| dma_dst_dec | output | 1 | DMA destination step mode |
| sat_repeat | output | 1 | Sprite-table auto-repeat |
| dma_start | output | 1 | One-cycle DMA start pulse |
| sat_request | output | 1 | One-cycle sprite-table transfer request |

## Verification
The bench drives several kinds of host traffic and compares every output on every cycle against a behavioural model:
- Index changes followed by writes to each byte lane show that writes land on the latched register and in the right byte.
- Writes to the ignored lanes and to empty indices show that such traffic disturbs nothing.
- Walking the increment and width codes through all four values tells the decode tables apart.
- Event pulses run under different enable masks, with status reads on each lane and an event in the very cycle of a read. These separate the sticky set, the clear-on-read and the priority between the two.

// File: rtl/vrb_pkg.sv
`timescale 1ns/1ps
// Package vrb_pkg
// Shared constants for the video register bank: bus widths, register
// indices, event bit positions and the small decode helpers.
// Assumes an 8-bit host bus and 16-bit indexed registers.
package vrb_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = 2 * DATA_W;
    localparam int IDX_W  = 5;
    localparam int EVT_W  = 6;
    localparam int N_WORD = 7;

    // Register indices that carry behaviour.
    localparam logic [IDX_W-1:0] IX_CTRL   = 5'd5;
    localparam logic [IDX_W-1:0] IX_LINE   = 5'd6;
    localparam logic [IDX_W-1:0] IX_HSCR   = 5'd7;
    localparam logic [IDX_W-1:0] IX_VSCR   = 5'd8;
    localparam logic [IDX_W-1:0] IX_MWIDTH = 5'd9;
    localparam logic [IDX_W-1:0] IX_DMACTL = 5'd15;
    localparam logic [IDX_W-1:0] IX_SRC    = 5'd16;
    localparam logic [IDX_W-1:0] IX_DST    = 5'd17;
    localparam logic [IDX_W-1:0] IX_LEN    = 5'd18;
    localparam logic [IDX_W-1:0] IX_SATSRC = 5'd19;

    // Slots of the plain 16-bit register array.
    localparam int WS_LINE = 0;
    localparam int WS_HSCR = 1;
    localparam int WS_VSCR = 2;
    localparam int WS_SRC  = 3;
    localparam int WS_DST  = 4;
    localparam int WS_LEN  = 5;
    localparam int WS_SAT  = 6;

    // Event / status bit positions.
    localparam int EV_COLL = 0;
    localparam int EV_OVF  = 1;
    localparam int EV_LINE = 2;
    localparam int EV_SAT  = 3;
    localparam int EV_DMA  = 4;
    localparam int EV_VBL  = 5;

    // Maps a slot of the plain register array to its host index.
    function automatic logic [IDX_W-1:0] word_index(input int slot);
        case (slot)
            WS_LINE: word_index = IX_LINE;
            WS_HSCR: word_index = IX_HSCR;
            WS_VSCR: word_index = IX_VSCR;
            WS_SRC:  word_index = IX_SRC;
            WS_DST:  word_index = IX_DST;
            WS_LEN:  word_index = IX_LEN;
            default: word_index = IX_SATSRC;
        endcase
    endfunction

    // Increment select code to address step: 1, 32, 64, 128.
    function automatic logic [DATA_W-1:0] step_of(input logic [1:0] code);
        logic [DATA_W-1:0] one;
        one = {{(DATA_W-1){1'b0}}, 1'b1};
        step_of = (code == 2'd0) ? one : (one << (32'(code) + 4));
    endfunction

endpackage

// File: rtl/vrb_decode.sv
`timescale 1ns/1ps
// Module vrb_decode
// Latches the register index and turns host writes into per-register
// byte-lane write strobes. Also flags status reads.
// Assumes host_wr and host_rd are never high together.
module vrb_decode
    import vrb_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int NW = N_WORD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_addr,
    input  logic [IW-1:0] idx_wdata,
    output logic [IW-1:0] idx_q,
    output logic          ctrl_we_lo,
    output logic          ctrl_we_hi,
    output logic          mw_we,
    output logic          dcr_we,
    output logic [NW-1:0] word_we_lo,
    output logic [NW-1:0] word_we_hi,
    output logic          status_rd
);

    logic data_wr;
    logic lane_hi;

    // Index latch: only a low-lane write at the index position loads it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (host_wr && host_addr == 2'b00)
            idx_q <= idx_wdata;
    end

    // Write strobes for the data positions.
    always_comb begin
        data_wr    = host_wr & host_addr[1];
        lane_hi    = host_addr[0];
        ctrl_we_lo = data_wr & ~lane_hi & (idx_q == IX_CTRL);
        ctrl_we_hi = data_wr &  lane_hi & (idx_q == IX_CTRL);
        mw_we      = data_wr & ~lane_hi & (idx_q == IX_MWIDTH);
        dcr_we     = data_wr & ~lane_hi & (idx_q == IX_DMACTL);
        status_rd  = host_rd & ~host_addr[1];
    end

    // Per-slot strobes for the plain 16-bit registers.
    for (genvar k = 0; k < NW; k++) begin : g_word_we
        assign word_we_lo[k] = data_wr & ~lane_hi & (idx_q == word_index(k));
        assign word_we_hi[k] = data_wr &  lane_hi & (idx_q == word_index(k));
    end

    // R1: a write at port 1 never disturbs the index.
    p_index_lane1_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'b01) |=> $stable(idx_q));

    // R12: one host write reaches at most one register lane.
    p_single_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({word_we_lo, word_we_hi, ctrl_we_lo, ctrl_we_hi, mw_we, dcr_we}));

endmodule

// File: rtl/vrb_word_reg.sv
`timescale 1ns/1ps
// Module vrb_word_reg
// One 16-bit register written one byte lane at a time.
// Assumes at most one lane strobe per cycle.
module vrb_word_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic [DW-1:0] wdata,
    output logic [2*DW-1:0] q
);

    // Byte-lane storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we_lo) q[DW-1:0]    <= wdata;
            if (we_hi) q[2*DW-1:DW] <= wdata;
        end
    end

    // R8: a high-lane write keeps the low byte.
    p_hi_keeps_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_hi && !we_lo) |=> $stable(q[DW-1:0]));

    // R8: a low-lane write keeps the high byte.
    p_lo_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_lo && !we_hi) |=> $stable(q[2*DW-1:DW]));

endmodule

// File: rtl/vrb_cfg.sv
`timescale 1ns/1ps
// Module vrb_cfg
// Holds the control, memory-width and DMA-control registers and
// decodes them into named fields and the six interrupt enables.
// Assumes the strobes come from vrb_decode (one at a time).
module vrb_cfg
    import vrb_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int EW = EVT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we_lo,
    input  logic          ctrl_we_hi,
    input  logic          mw_we,
    input  logic          dcr_we,
    input  logic [DW-1:0] wdata,
    output logic [EW-1:0] irq_en,
    output logic [1:0]    sync_mode,
    output logic          sprite_on,
    output logic          bg_on,
    output logic [1:0]    disp_mode,
    output logic          refresh_on,
    output logic [DW-1:0] vram_step,
    output logic [1:0]    vram_timing,
    output logic [1:0]    sprite_timing,
    output logic [DW-1:0] map_width,
    output logic [6:0]    map_height,
    output logic          colour_mode,
    output logic          dma_src_dec,
    output logic          dma_dst_dec,
    output logic          sat_repeat
);

    logic [DW-1:0] ctrl_lo_q;
    logic [1:0]    disp_q;
    logic          refresh_q;
    logic [DW-1:0] step_q;
    logic [DW-1:0] mw_q;
    logic [4:0]    dcr_q;

    // Control register, both lanes; the step is kept already decoded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_lo_q <= '0;
            disp_q    <= '0;
            refresh_q <= 1'b0;
            step_q    <= step_of(2'd0);
        end else begin
            if (ctrl_we_lo) ctrl_lo_q <= wdata;
            if (ctrl_we_hi) begin
                disp_q    <= wdata[1:0];
                refresh_q <= wdata[2];
                step_q    <= step_of(wdata[4:3]);
            end
        end
    end

    // Memory-width and DMA-control registers, low lane only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_q  <= '0;
            dcr_q <= '0;
        end else begin
            if (mw_we)  mw_q  <= wdata;
            if (dcr_we) dcr_q <= wdata[4:0];
        end
    end

    // Field decode.
    always_comb begin
        irq_en           = '0;
        irq_en[EV_COLL]  = ctrl_lo_q[0];
        irq_en[EV_OVF]   = ctrl_lo_q[1];
        irq_en[EV_LINE]  = ctrl_lo_q[2];
        irq_en[EV_VBL]   = ctrl_lo_q[3];
        irq_en[EV_DMA]   = dcr_q[0];
        irq_en[EV_SAT]   = dcr_q[1];
        sync_mode        = ctrl_lo_q[5:4];
        sprite_on        = ctrl_lo_q[6];
        bg_on            = ctrl_lo_q[7];
        disp_mode        = disp_q;
        refresh_on       = refresh_q;
        vram_step        = step_q;
        vram_timing      = mw_q[1:0];
        sprite_timing    = mw_q[3:2];
        case (mw_q[5:4])
            2'd0:    map_width = DW'(32);
            2'd1:    map_width = DW'(64);
            default: map_width = DW'(128);
        endcase
        map_height       = mw_q[6] ? 7'd64 : 7'd32;
        colour_mode      = mw_q[7];
        dma_src_dec      = dcr_q[2];
        dma_dst_dec      = dcr_q[3];
        sat_repeat       = dcr_q[4];
    end

    // R6: the step only ever takes one of the four legal values.
    p_step_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_step == DW'(1)) || (vram_step == DW'(32)) ||
        (vram_step == DW'(64)) || (vram_step == DW'(128)));

    // R5: a high-lane control write leaves the low-lane fields alone.
    p_ctrl_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we_hi && !ctrl_we_lo) |=> ($stable(sync_mode) && $stable(sprite_on) && $stable(bg_on)));

endmodule

// File: rtl/vrb_irq.sv
`timescale 1ns/1ps
// Module vrb_irq
// Sticky interrupt-pending flags, cleared by a status read, and the
// combined interrupt line.
// Assumes event inputs are single-cycle pulses; an event coinciding
// with a clear wins.
module vrb_irq #(
    parameter int EW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] evt,
    input  logic [EW-1:0] irq_en,
    input  logic          status_clr,
    output logic [EW-1:0] pending,
    output logic          irq
);

    // Pending flags: set by events, cleared by status reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else if (status_clr)
            pending <= evt;
        else
            pending <= pending | evt;
    end

    // Interrupt line from enabled pending flags.
    always_comb irq = |(pending & irq_en);

    // R3: a read with no coincident event empties the flags.
    p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && evt == '0) |=> (pending == '0));

    // R4: without a read, no flag that was set drops.
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_clr) |=> ((pending & $past(pending)) == $past(pending)));

    // R4: every event pulse leaves its flag set.
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((pending & $past(evt)) == $past(evt)));

endmodule

// File: rtl/vrb_top.sv
`timescale 1ns/1ps
// Module vrb_top
// Host register bank of a video controller: indexed byte-lane access,
// status with clear-on-read, decoded configuration fields, scroll and
// DMA registers, and the DMA trigger pulses.
// Assumes host_wr and host_rd are exclusive and events last one cycle.
module vrb_top
    import vrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [EVT_W-1:0]  evt_pulse,
    output logic              irq,
    output logic [1:0]        sync_mode,
    output logic              sprite_on,
    output logic              bg_on,
    output logic [1:0]        disp_mode,
    output logic              refresh_on,
    output logic [DATA_W-1:0] vram_step,
    output logic [1:0]        vram_timing,
    output logic [1:0]        sprite_timing,
    output logic [DATA_W-1:0] map_width,
    output logic [6:0]        map_height,
    output logic              colour_mode,
    output logic [WORD_W-1:0] line_compare,
    output logic [WORD_W-1:0] hscroll,
    output logic [WORD_W-1:0] vscroll,
    output logic [WORD_W-1:0] vline_count,
    output logic [WORD_W-1:0] dma_src,
    output logic [WORD_W-1:0] dma_dst,
    output logic [WORD_W-1:0] dma_len,
    output logic [WORD_W-1:0] sat_src,
    output logic              dma_src_dec,
    output logic              dma_dst_dec,
    output logic              sat_repeat,
    output logic              dma_start,
    output logic              sat_request
);

    localparam int PAD_W = DATA_W - EVT_W;

    logic [IDX_W-1:0]  idx_q;
    logic              ctrl_we_lo;
    logic              ctrl_we_hi;
    logic              mw_we;
    logic              dcr_we;
    logic [N_WORD-1:0] word_we_lo;
    logic [N_WORD-1:0] word_we_hi;
    logic              status_rd;
    logic [EVT_W-1:0]  irq_en;
    logic [EVT_W-1:0]  pending;
    logic [WORD_W-1:0] word_q [N_WORD];

    vrb_decode #(.IW(IDX_W), .NW(N_WORD)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .idx_wdata  (host_wdata[IDX_W-1:0]),
        .idx_q      (idx_q),
        .ctrl_we_lo (ctrl_we_lo),
        .ctrl_we_hi (ctrl_we_hi),
        .mw_we      (mw_we),
        .dcr_we     (dcr_we),
        .word_we_lo (word_we_lo),
        .word_we_hi (word_we_hi),
        .status_rd  (status_rd)
    );

    vrb_cfg #(.DW(DATA_W), .EW(EVT_W)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_we_lo    (ctrl_we_lo),
        .ctrl_we_hi    (ctrl_we_hi),
        .mw_we         (mw_we),
        .dcr_we        (dcr_we),
        .wdata         (host_wdata),
        .irq_en        (irq_en),
        .sync_mode     (sync_mode),
        .sprite_on     (sprite_on),
        .bg_on         (bg_on),
        .disp_mode     (disp_mode),
        .refresh_on    (refresh_on),
        .vram_step     (vram_step),
        .vram_timing   (vram_timing),
        .sprite_timing (sprite_timing),
        .map_width     (map_width),
        .map_height    (map_height),
        .colour_mode   (colour_mode),
        .dma_src_dec   (dma_src_dec),
        .dma_dst_dec   (dma_dst_dec),
        .sat_repeat    (sat_repeat)
    );

    vrb_irq #(.EW(EVT_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_pulse),
        .irq_en     (irq_en),
        .status_clr (status_rd),
        .pending    (pending),
        .irq        (irq)
    );

    // One byte-lane register per slot of the plain register array.
    for (genvar k = 0; k < N_WORD; k++) begin : g_word
        vrb_word_reg #(.DW(DATA_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (word_we_lo[k]),
            .we_hi (word_we_hi[k]),
            .wdata (host_wdata),
            .q     (word_q[k])
        );
    end

    // Named views of the plain registers.
    always_comb begin
        line_compare = word_q[WS_LINE];
        hscroll      = word_q[WS_HSCR];
        vscroll      = word_q[WS_VSCR];
        dma_src      = word_q[WS_SRC];
        dma_dst      = word_q[WS_DST];
        dma_len      = word_q[WS_LEN];
        sat_src      = word_q[WS_SAT];
    end

    // Status byte; only a low-lane read at the index position returns flags.
    always_comb begin
        if (status_rd && !host_addr[0])
            host_rdata = {{PAD_W{1'b0}}, pending};
        else
            host_rdata = '0;
    end

    // Vertical counter reloads with the merged scroll value on any scroll write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vline_count <= '0;
        else if (word_we_lo[WS_VSCR] || word_we_hi[WS_VSCR])
            vline_count <= {word_we_hi[WS_VSCR] ? host_wdata : vscroll[WORD_W-1:DATA_W],
                            word_we_lo[WS_VSCR] ? host_wdata : vscroll[DATA_W-1:0]};
    end

    // Trigger pulses from high-lane writes to the length and sprite-table source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start   <= 1'b0;
            sat_request <= 1'b0;
        end else begin
            dma_start   <= word_we_hi[WS_LEN];
            sat_request <= word_we_hi[WS_SAT];
        end
    end

    // R9: after a scroll write the counter equals the scroll register.
    p_vcount_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we_lo[WS_VSCR] || word_we_hi[WS_VSCR]) |=> (vline_count == vscroll));

    // R11: a DMA start pulse always follows a high-lane host write.
    p_dma_start_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(host_wr && host_addr == 2'b11));

    // R11: a sprite-table request always follows a high-lane host write.
    p_sat_req_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sat_request |-> $past(host_wr && host_addr == 2'b11));

    // R2: reads away from port 0 return zero.
    p_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr != 2'b00) |-> (host_rdata == '0));

endmodule

// File: tb/sim_vrb_top.sv
`timescale 1ns/1ps
// Bench for vrb_top: a behavioural model updated on every edge and
// compared against all outputs every cycle, plus directed checks.
module sim_vrb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_addr = 2'b00;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [5:0]  evt_pulse = 6'h00;
    logic        irq;
    logic [1:0]  sync_mode, disp_mode, vram_timing, sprite_timing;
    logic        sprite_on, bg_on, refresh_on, colour_mode;
    logic [7:0]  vram_step, map_width;
    logic [6:0]  map_height;
    logic [15:0] line_compare, hscroll, vscroll, vline_count;
    logic [15:0] dma_src, dma_dst, dma_len, sat_src;
    logic        dma_src_dec, dma_dst_dec, sat_repeat, dma_start, sat_request;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vrb_top u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_pulse(evt_pulse), .irq(irq), .sync_mode(sync_mode),
        .sprite_on(sprite_on), .bg_on(bg_on), .disp_mode(disp_mode),
        .refresh_on(refresh_on), .vram_step(vram_step), .vram_timing(vram_timing),
        .sprite_timing(sprite_timing), .map_width(map_width), .map_height(map_height),
        .colour_mode(colour_mode), .line_compare(line_compare), .hscroll(hscroll),
        .vscroll(vscroll), .vline_count(vline_count), .dma_src(dma_src),
        .dma_dst(dma_dst), .dma_len(dma_len), .sat_src(sat_src),
        .dma_src_dec(dma_src_dec), .dma_dst_dec(dma_dst_dec),
        .sat_repeat(sat_repeat), .dma_start(dma_start), .sat_request(sat_request)
    );

    // Model state.
    logic [4:0]  m_idx;
    logic [5:0]  m_pend;
    logic [7:0]  m_clo, m_mw;
    logic [4:0]  m_chi, m_dcr;
    logic [15:0] m_word [0:31];
    logic [15:0] m_vc;
    bit          m_start, m_sat;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_idx = '0; m_pend = '0; m_clo = '0; m_mw = '0; m_chi = '0; m_dcr = '0;
        for (int i = 0; i < 32; i++) m_word[i] = '0;
        m_vc = '0; m_start = 0; m_sat = 0;
    endtask

    function automatic bit is_word(input logic [4:0] ix);
        return ix == 6 || ix == 7 || ix == 8 || (ix >= 16 && ix <= 19);
    endfunction

    task automatic model_edge(input bit w, input bit r, input logic [1:0] a,
                              input logic [7:0] d, input logic [5:0] ev);
        m_start = 0;
        m_sat   = 0;
        if (r && !a[1]) m_pend = ev; else m_pend = m_pend | ev;
        if (w) begin
            if (a == 2'b00) m_idx = d[4:0];
            else if (a[1]) begin
                if (m_idx == 5) begin
                    if (a[0]) m_chi = d[4:0]; else m_clo = d;
                end else if (m_idx == 9) begin
                    if (!a[0]) m_mw = d;
                end else if (m_idx == 15) begin
                    if (!a[0]) m_dcr = d[4:0];
                end else if (is_word(m_idx)) begin
                    if (a[0]) m_word[m_idx][15:8] = d; else m_word[m_idx][7:0] = d;
                    if (m_idx == 8) m_vc = m_word[8];
                    if (m_idx == 18 && a[0]) m_start = 1;
                    if (m_idx == 19 && a[0]) m_sat = 1;
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [5:0] en;
        logic [7:0] stp, wid;
        en = {m_clo[3], m_dcr[0], m_dcr[1], m_clo[2], m_clo[1], m_clo[0]};
        case (m_chi[4:3]) 2'd0: stp = 1; 2'd1: stp = 32; 2'd2: stp = 64; default: stp = 128; endcase
        case (m_mw[5:4]) 2'd0: wid = 32; 2'd1: wid = 64; default: wid = 128; endcase
        chk("R4 irq", irq, |(m_pend & en));
        chk("R5 sync_mode", sync_mode, m_clo[5:4]);
        chk("R5 sprite_on", sprite_on, m_clo[6]);
        chk("R5 bg_on", bg_on, m_clo[7]);
        chk("R5 disp_mode", disp_mode, m_chi[1:0]);
        chk("R5 refresh_on", refresh_on, m_chi[2]);
        chk("R6 vram_step", vram_step, stp);
        chk("R7 vram_timing", vram_timing, m_mw[1:0]);
        chk("R7 sprite_timing", sprite_timing, m_mw[3:2]);
        chk("R7 map_width", map_width, wid);
        chk("R7 map_height", map_height, m_mw[6] ? 64 : 32);
        chk("R7 colour_mode", colour_mode, m_mw[7]);
        chk("R8 line_compare", line_compare, m_word[6]);
        chk("R8 hscroll", hscroll, m_word[7]);
        chk("R8 vscroll", vscroll, m_word[8]);
        chk("R8 dma_src", dma_src, m_word[16]);
        chk("R8 dma_dst", dma_dst, m_word[17]);
        chk("R8 dma_len", dma_len, m_word[18]);
        chk("R8 sat_src", sat_src, m_word[19]);
        chk("R9 vline_count", vline_count, m_vc);
        chk("R10 dma_src_dec", dma_src_dec, m_dcr[2]);
        chk("R10 dma_dst_dec", dma_dst_dec, m_dcr[3]);
        chk("R10 sat_repeat", sat_repeat, m_dcr[4]);
        chk("R11 dma_start", dma_start, m_start);
        chk("R11 sat_request", sat_request, m_sat);
    endtask

    // One clock: check read data before the edge, update model, compare after.
    task automatic tick();
        bit w, r;
        logic [1:0] a;
        logic [7:0] d;
        logic [5:0] ev;
        #1;
        w = host_wr; r = host_rd; a = host_addr; d = host_wdata; ev = evt_pulse;
        chk("R2 host_rdata", host_rdata, (r && a == 2'b00) ? {2'b00, m_pend} : 8'h00);
        @(posedge clk);
        model_edge(w, r, a, d, ev);
        #1;
        compare_all();
        host_wr = 0; host_rd = 0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        tick();
    endtask

    task automatic rd(input logic [1:0] a);
        host_rd = 1; host_addr = a;
        tick();
    endtask

    task automatic event_pulse(input logic [5:0] ev);
        evt_pulse = ev;
        tick();
    endtask

    task automatic wr16(input logic [4:0] ix, input logic [15:0] v);
        wr(2'b00, {3'b000, ix});
        wr(2'b10, v[7:0]);
        wr(2'b11, v[15:8]);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        compare_all();
        chk("R12 reset step", vram_step, 8'd1);
        chk("R12 reset width", map_width, 8'd32);

        // R1: index from lane 0 only.
        wr(2'b00, 8'hE7);               // bits 4:0 -> 7
        wr(2'b01, 8'h09);               // ignored
        wr(2'b10, 8'h34);
        chk("R1 index via low lane", hscroll, 16'h0034);

        // R5 / R6: control fields and all increment codes.
        wr(2'b00, 8'd5);
        wr(2'b10, 8'hA5);
        wr(2'b11, 8'h1F);
        chk("R6 step code 3", vram_step, 8'd128);
        wr(2'b11, 8'h08);
        chk("R6 step code 1", vram_step, 8'd32);
        wr(2'b11, 8'h12);
        chk("R6 step code 2", vram_step, 8'd64);
        wr(2'b11, 8'h05);
        chk("R6 step code 0", vram_step, 8'd1);

        // R7: memory width, hi lane ignored, all width codes.
        wr(2'b00, 8'd9);
        wr(2'b10, 8'hE6);
        chk("R7 width code 2", map_width, 8'd128);
        wr(2'b11, 8'h00);
        chk("R7 hi lane ignored", map_height, 7'd64);
        wr(2'b10, 8'h35);
        wr(2'b10, 8'h1A);
        wr(2'b10, 8'h0B);

        // R10: DMA control, hi lane ignored.
        wr(2'b00, 8'd15);
        wr(2'b10, 8'h1F);
        wr(2'b11, 8'h00);
        chk("R10 hi lane ignored", sat_repeat, 1'b1);

        // R8 / R9 / R11: word registers, counter reload, pulses.
        wr16(5'd6, 16'h1234);
        wr16(5'd7, 16'hBEEF);
        wr(2'b00, 8'd8);
        wr(2'b10, 8'h5A);
        chk("R9 counter after low write", vline_count, 16'h005A);
        wr(2'b11, 8'hC3);
        chk("R9 counter after high write", vline_count, 16'hC35A);
        wr16(5'd16, 16'h0102);
        wr16(5'd17, 16'h0304);
        wr(2'b00, 8'd18);
        wr(2'b10, 8'h40);
        chk("R11 no pulse on low lane", dma_start, 1'b0);
        wr(2'b11, 8'h01);
        chk("R11 start pulse", dma_start, 1'b1);
        tick();
        chk("R11 start pulse ends", dma_start, 1'b0);
        wr(2'b00, 8'd19);
        wr(2'b10, 8'h80);
        wr(2'b11, 8'h7F);
        chk("R11 sat request", sat_request, 1'b1);
        wr(2'b11, 8'h7E);
        wr(2'b11, 8'h7D);

        // R12: unassigned indices leave everything unchanged.
        for (int ix = 0; ix < 32; ix++) begin
            if (!(ix == 5 || ix == 9 || ix == 15 || is_word(5'(ix)))) begin
                wr(2'b00, 8'(ix));
                wr(2'b10, 8'hFF);
                wr(2'b11, 8'hFF);
            end
        end
        chk("R12 unassigned keeps hscroll", hscroll, 16'hBEEF);

        // R2 / R3 / R4: status and interrupts.
        rd(2'b00);
        event_pulse(6'b100100);
        host_rd = 1; host_addr = 2'b00; #1;
        chk("R2 status bit order", host_rdata, 8'h24);
        tick();
        rd(2'b00);
        rd(2'b00);
        event_pulse(6'b000001);
        chk("R4 collision irq", irq, 1'b1);
        rd(2'b01);
        chk("R3 lane1 read clears irq", irq, 1'b0);
        event_pulse(6'b001000);
        chk("R4 sat-done irq enabled", irq, 1'b1);
        host_rd = 1; host_addr = 2'b01; evt_pulse = 6'b010000; #1;
        chk("R2 lane1 status reads zero", host_rdata, 8'h00);
        tick();
        chk("R3 event wins over clear", irq, 1'b1);
        rd(2'b00);
        wr(2'b00, 8'd5);
        wr(2'b10, 8'h00);
        wr(2'b00, 8'd15);
        wr(2'b10, 8'h00);
        event_pulse(6'b111111);
        chk("R4 disabled flags no irq", irq, 1'b0);
        wr(2'b00, 8'd5);
        wr(2'b10, 8'h08);
        chk("R4 vblank enable raises irq", irq, 1'b1);
        host_rd = 1; host_addr = 2'b00; #1;
        chk("R2 all flags", host_rdata, 8'h3F);
        tick();
        rd(2'b10);
        rd(2'b11);
        repeat (3) tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule